// File: doc/BRIEF.md
# Full-Frame Antenna Chip Store

This block keeps every oversampled antenna chip of a radio frame in a circular on-chip store, so a despreader can make a single pass over a frame once that frame's spreading factor has been decoded. Samples arrive one per cycle through a write port. Each sample carries an in-phase rail and a quadrature rail. The block counts samples into frames and pulses a completion strobe with the frame's index when the last sample of a frame lands. The oldest stored frame can only be read once all of its samples are present.

A despreader names a frame, a chip offset and a sample phase, and gets the sample one cycle later. When it has finished with the oldest frame, it releases that frame, and the space is handed back to the writer. The store holds the frame length times a margin (thirteen tenths by default), rounded up. Once the store is full of unreleased samples, further writes are dropped and a sticky overrun flag is raised, so a frame still waiting for readout is never corrupted.

Top module: `chip_frame_buf`

## Requirements
- R1: While reset is asserted, frm_done, frm_rdy, ovr and rd_vld are 0 and oldest_idx is 0.
- R2: Frames are numbered from 0 after reset and wrap modulo 2^FIW. In the cycle after the accepted write of a frame's final sample (sample CHIPS*SPC-1 of that frame), frm_done is 1 for exactly one cycle and frm_done_idx equals that frame's number.
- R3: A write offered while the store holds DEPTH unreleased samples is dropped. The store contents are unchanged and the dropped sample does not advance the position within the frame. ovr goes to 1 and stays there until reset.
- R4: frm_rdy is 1 exactly when the frame numbered oldest_idx has had all its samples written.
- R5: A read request with frm_rdy=1, rd_frm=oldest_idx, rd_chip<CHIPS and rd_ph<SPC gives rd_vld=1 in the next cycle. rd_i/rd_q then carry sample number rd_chip*SPC+rd_ph of that frame, where samples are numbered in write order.
- R6: A read request that breaks any condition of R5 gives rd_vld=0 in the next cycle.
- R7: rel with frm_rdy=1 frees the oldest frame, and oldest_idx increases by one. rel with frm_rdy=0 is ignored, and oldest_idx is unchanged.
- R8: Storage is circular over DEPTH slots, including non-power-of-two depths. A frame whose samples wrap past the last slot reads back in order.
- R9: DEPTH = ceil(CHIPS*SPC*MARGIN_X10/10). With nothing released, exactly DEPTH writes are accepted before the first overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_vld | input | 1 | Sample present on the write port |
| wr_i | input | IW | In-phase part of the incoming sample |
| wr_q | input | IW | Quadrature part of the incoming sample |
| rd_en | input | 1 | Read request |
| rd_frm | input | FIW | Frame number requested |
| rd_chip | input | CW | Chip offset inside the frame |
| rd_ph | input | PW | Sample phase inside the chip |
| rel | input | 1 | Release the oldest complete frame |
| rd_vld | output | 1 | Read data valid (one cycle after request) |
| rd_i | output | IW | In-phase part of read sample (0 when not valid) |
| rd_q | output | IW | Quadrature part of read sample (0 when not valid) |
| frm_done | output | 1 | One-cycle strobe: a frame just completed |
| frm_done_idx | output | FIW | Number of the frame that completed |
| frm_rdy | output | 1 | Oldest unreleased frame is complete |
| oldest_idx | output | FIW | Number of the oldest unreleased frame |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with 7 chips per frame, 2 samples per chip, 8-bit rails and a 3-bit frame number. This gives 14-sample frames in a 19-slot store. Because 19 is not a power of two, the subtract-based wrap is exercised, and the second frame straddles the end of the store. Because 7 chips do not fill the 3-bit chip field, an out-of-range chip request can be made. Since only a few samples fit beyond one frame, overrun is reached after five extra writes. With nine frames written, the frame number wraps back to 0.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

   // slots needed for one frame plus margin (margin given in tenths), rounded up
   function automatic int calc_depth(input int frame_s, input int mx10);
      return (frame_s * mx10 + 9) / 10;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cfb_wr_ctrl.sv
module cfb_wr_ctrl #(
   parameter int FRAME_S = 14,
   parameter int DEPTH   = 19,
   parameter int AW      = 5,
   parameter int FIW     = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_vld,
   input  logic           space_ok,
   output logic           wr_acc,
   output logic [AW-1:0]  wr_addr,
   output logic [FIW-1:0] wfi,
   output logic           done,
   output logic [FIW-1:0] done_idx
);
   localparam int SIW = (FRAME_S > 1) ? $clog2(FRAME_S) : 1;
   localparam logic [AW-1:0]  LAST_A = AW'(DEPTH - 1);
   localparam logic [SIW-1:0] LAST_S = SIW'(FRAME_S - 1);

   logic [SIW-1:0] sidx;

   assign wr_acc = wr_vld & space_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_addr  <= '0;
         sidx     <= '0;
         wfi      <= '0;
         done     <= 1'b0;
         done_idx <= '0;
      end else begin
         done <= 1'b0;
         if (wr_acc) begin
            wr_addr <= (wr_addr == LAST_A) ? '0 : wr_addr + 1'b1;
            if (sidx == LAST_S) begin
               sidx     <= '0;
               wfi      <= wfi + 1'b1;
               done     <= 1'b1;
               done_idx <= wfi;
            end else begin
               sidx <= sidx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cfb_occ.sv
module cfb_occ #(
   parameter int FRAME_S = 14,
   parameter int DEPTH   = 19,
   parameter int AW      = 5,
   parameter int FIW     = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_vld,
   input  logic           wr_acc,
   input  logic           rel,
   input  logic [FIW-1:0] wfi,
   output logic           space_ok,
   output logic [FIW-1:0] ofi,
   output logic [AW-1:0]  obase,
   output logic           rdy,
   output logic           ovr
);
   localparam int FLW = $clog2(DEPTH + 1);

   logic [FLW-1:0] fill, fill_n;
   logic [AW:0]    bsum;
   logic [AW-1:0]  base_n;
   logic           rel_acc;

   assign rdy      = (wfi != ofi);
   assign rel_acc  = rel & rdy;
   assign space_ok = (fill != FLW'(DEPTH));

   always_comb begin
      fill_n = fill;
      if (wr_acc)  fill_n = fill_n + 1'b1;
      if (rel_acc) fill_n = fill_n - FLW'(FRAME_S);
   end

   // next frame base: one frame further, folded once into [0, DEPTH)
   assign bsum   = {1'b0, obase} + (AW+1)'(FRAME_S);
   assign base_n = (bsum >= (AW+1)'(DEPTH)) ? AW'(bsum - (AW+1)'(DEPTH)) : bsum[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill  <= '0;
         ofi   <= '0;
         obase <= '0;
         ovr   <= 1'b0;
      end else begin
         fill <= fill_n;
         if (wr_vld && !space_ok) ovr <= 1'b1;
         if (rel_acc) begin
            ofi   <= ofi + 1'b1;
            obase <= base_n;
         end
      end
   end
endmodule

// File: rtl/cfb_addr.sv
module cfb_addr #(
   parameter int DEPTH = 19,
   parameter int AW    = 5
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] off,
   output logic [AW-1:0] addr
);
   if (cfb_pkg::is_pow2(DEPTH)) begin : g_mask
      assign addr = base + off;
   end else begin : g_sub
      logic [AW:0] sum;
      assign sum  = {1'b0, base} + {1'b0, off};
      assign addr = (sum >= (AW+1)'(DEPTH)) ? AW'(sum - (AW+1)'(DEPTH)) : sum[AW-1:0];
   end
endmodule

// File: rtl/cfb_mem.sv
module cfb_mem #(
   parameter int SW    = 16,
   parameter int DEPTH = 19,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [SW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [SW-1:0] rdata
);
   logic [SW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/chip_frame_buf.sv
module chip_frame_buf #(
   parameter  int CHIPS      = 512,
   parameter  int SPC        = 2,
   parameter  int IW         = 8,
   parameter  int MARGIN_X10 = 13,
   parameter  int FIW        = 4,
   localparam int FRAME_S    = CHIPS * SPC,
   localparam int DEPTH      = cfb_pkg::calc_depth(FRAME_S, MARGIN_X10),
   localparam int AW         = $clog2(DEPTH),
   localparam int CW         = (CHIPS > 1) ? $clog2(CHIPS) : 1,
   localparam int PW         = (SPC > 1) ? $clog2(SPC) : 1,
   localparam int SW         = 2 * IW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_vld,
   input  logic [IW-1:0]  wr_i,
   input  logic [IW-1:0]  wr_q,
   input  logic           rd_en,
   input  logic [FIW-1:0] rd_frm,
   input  logic [CW-1:0]  rd_chip,
   input  logic [PW-1:0]  rd_ph,
   input  logic           rel,
   output logic           rd_vld,
   output logic [IW-1:0]  rd_i,
   output logic [IW-1:0]  rd_q,
   output logic           frm_done,
   output logic [FIW-1:0] frm_done_idx,
   output logic           frm_rdy,
   output logic [FIW-1:0] oldest_idx,
   output logic           ovr
);
   // elaboration-time parameter checks
   if (CHIPS < 2) begin : g_bad_chips
      $error("chip_frame_buf: CHIPS must be at least 2");
   end
   if (SPC < 1) begin : g_bad_spc
      $error("chip_frame_buf: SPC must be at least 1");
   end
   if (IW < 1) begin : g_bad_iw
      $error("chip_frame_buf: IW must be at least 1");
   end
   if (MARGIN_X10 < 11 || MARGIN_X10 > 19) begin : g_bad_margin
      $error("chip_frame_buf: MARGIN_X10 must lie in 11..19");
   end
   if (FIW < 2) begin : g_bad_fiw
      $error("chip_frame_buf: FIW must be at least 2");
   end

   logic          wr_acc, space_ok, rdy, rd_ok, chip_ok, ph_ok, done;
   logic [AW-1:0] wr_addr, obase, off, raddr;
   logic [FIW-1:0] wfi, ofi, done_idx;
   logic [SW-1:0] dout;

   cfb_wr_ctrl #(.FRAME_S(FRAME_S), .DEPTH(DEPTH), .AW(AW), .FIW(FIW)) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .space_ok(space_ok),
      .wr_acc(wr_acc), .wr_addr(wr_addr), .wfi(wfi), .done(done), .done_idx(done_idx)
   );

   cfb_occ #(.FRAME_S(FRAME_S), .DEPTH(DEPTH), .AW(AW), .FIW(FIW)) u_occ (
      .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_acc(wr_acc), .rel(rel), .wfi(wfi),
      .space_ok(space_ok), .ofi(ofi), .obase(obase), .rdy(rdy), .ovr(ovr)
   );

   // range checks vanish when the field exactly spans the legal values
   if (CHIPS == (1 << CW)) begin : g_chip_full
      assign chip_ok = 1'b1;
   end else begin : g_chip_lim
      assign chip_ok = (rd_chip < CW'(CHIPS));
   end
   if (SPC == (1 << PW)) begin : g_ph_full
      assign ph_ok = 1'b1;
   end else begin : g_ph_lim
      assign ph_ok = (rd_ph < PW'(SPC));
   end

   assign rd_ok = rd_en & rdy & (rd_frm == ofi) & chip_ok & ph_ok;
   assign off   = AW'(rd_chip) * AW'(SPC) + AW'(rd_ph);

   cfb_addr #(.DEPTH(DEPTH), .AW(AW)) u_addr (
      .base(obase), .off(off), .addr(raddr)
   );

   cfb_mem #(.SW(SW), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk(clk), .we(wr_acc), .waddr(wr_addr), .wdata({wr_i, wr_q}),
      .re(rd_ok), .raddr(raddr), .rdata(dout)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rd_vld <= 1'b0;
      else        rd_vld <= rd_ok;
   end

   assign rd_i         = rd_vld ? dout[SW-1:IW] : '0;
   assign rd_q         = rd_vld ? dout[IW-1:0]  : '0;
   assign frm_done     = done;
   assign frm_done_idx = done_idx;
   assign frm_rdy      = rdy;
   assign oldest_idx   = ofi;
endmodule

// File: rtl/cfb_chk.sv
module cfb_chk #(
   parameter int FIW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_vld,
   input logic           rel,
   input logic           rd_en,
   input logic [FIW-1:0] rd_frm,
   input logic           frm_done,
   input logic           frm_rdy,
   input logic [FIW-1:0] oldest_idx,
   input logic           ovr,
   input logic           rd_vld
);
   localparam logic [FIW-1:0] ONE = 1;

   p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> ovr);

   p_ovr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(wr_vld));

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |=> !frm_done);

   p_done_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |-> $past(wr_vld));

   p_done_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |-> frm_rdy);

   p_rel_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rel && !frm_rdy) |=> $stable(oldest_idx));

   p_rel_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rel && frm_rdy) |=> (oldest_idx == $past(oldest_idx) + ONE));

   p_rd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> $past(rd_en && frm_rdy && (rd_frm == oldest_idx)));
endmodule

bind chip_frame_buf cfb_chk #(.FIW(FIW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .rel(rel), .rd_en(rd_en),
   .rd_frm(rd_frm), .frm_done(frm_done), .frm_rdy(frm_rdy),
   .oldest_idx(oldest_idx), .ovr(ovr), .rd_vld(rd_vld)
);

// File: tb/sim_chip_frame_buf.sv
module sim_chip_frame_buf;
   localparam int CHIPS = 7, SPC = 2, IW = 8, MX = 13, FIW = 3;
   localparam int FS = CHIPS * SPC;   // 14
   localparam int DEPTH = 19;         // ceil(14*1.3)

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic wr_vld = 0, rd_en = 0, rel = 0;
   logic [IW-1:0] wr_i = '0, wr_q = '0;
   logic [FIW-1:0] rd_frm = '0;
   logic [2:0] rd_chip = '0;
   logic [0:0] rd_ph = '0;
   logic rd_vld, frm_done, frm_rdy, ovr;
   logic [IW-1:0] rd_i, rd_q;
   logic [FIW-1:0] frm_done_idx, oldest_idx;

   chip_frame_buf #(.CHIPS(CHIPS), .SPC(SPC), .IW(IW), .MARGIN_X10(MX), .FIW(FIW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_i(wr_i), .wr_q(wr_q),
      .rd_en(rd_en), .rd_frm(rd_frm), .rd_chip(rd_chip), .rd_ph(rd_ph), .rel(rel),
      .rd_vld(rd_vld), .rd_i(rd_i), .rd_q(rd_q), .frm_done(frm_done),
      .frm_done_idx(frm_done_idx), .frm_rdy(frm_rdy), .oldest_idx(oldest_idx), .ovr(ovr)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   typedef struct { bit vld; logic [15:0] d; string req; } exp_t;
   exp_t sb[$];

   function automatic logic [15:0] smp(input int f, input int n);
      logic [7:0] a;
      a = 8'(f * 16 + n);
      return {a, a ^ 8'h5a};
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // monitor: pops one expectation per accepted read request
   initial begin
      bit taken;
      exp_t e;
      forever begin
         @(posedge clk);
         taken = rd_en && rst_n;
         #1;
         if (taken) begin
            if (sb.size() == 0) chk(0, "R5 (no expectation)", 0, 1);
            else begin
               e = sb.pop_front();
               if (e.vld) chk(rd_vld === 1'b1 && {rd_i, rd_q} === e.d, e.req,
                              {rd_vld, rd_i, rd_q}, {1'b1, e.d});
               else       chk(rd_vld === 1'b0, e.req, rd_vld, 0);
            end
         end
      end
   end

   // driver tasks: called at a falling edge, return at the next one
   task automatic wr1(input logic [15:0] d, input bit exp_done, input int exp_idx);
      wr_vld = 1; {wr_i, wr_q} = d;
      @(negedge clk);
      wr_vld = 0;
      if (exp_done) chk(frm_done === 1'b1 && frm_done_idx === FIW'(exp_idx), "R2 done strobe",
                        {frm_done, frm_done_idx}, {1'b1, FIW'(exp_idx)});
      else          chk(frm_done === 1'b0, "R2 no strobe", frm_done, 0);
   endtask

   task automatic wr_range(input int f, input int from, input int to);
      for (int n = from; n <= to; n++) wr1(smp(f, n), n == FS - 1, f % 8);
   endtask

   task automatic rdq(input int f, input int c, input int p, input bit v, input logic [15:0] d,
                      input string req);
      exp_t e;
      rd_en = 1; rd_frm = FIW'(f); rd_chip = 3'(c); rd_ph = 1'(p);
      e.vld = v; e.d = d; e.req = req;
      sb.push_back(e);
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic rel1();
      rel = 1;
      @(negedge clk);
      rel = 0;
   endtask

   initial begin
      #(4 * 20000);
      chk(0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(frm_done === 0 && frm_rdy === 0 && ovr === 0 && rd_vld === 0 && oldest_idx === 0,
          "R1 reset outputs", {frm_done, frm_rdy, ovr, rd_vld, oldest_idx}, 0);
      rst_n = 1;
      @(negedge clk);

      // R6: nothing complete yet
      rdq(0, 0, 0, 0, 0, "R6 read before frame complete");
      wr_range(0, 0, FS - 2);
      chk(frm_rdy === 0, "R4 not ready with one sample missing", frm_rdy, 0);
      rdq(0, 1, 0, 0, 0, "R6 read of partial frame");
      wr_range(0, FS - 1, FS - 1);
      chk(frm_rdy === 1, "R4 ready after last sample", frm_rdy, 1);

      // R5: read frame 0 in reversed chip order
      for (int c = CHIPS - 1; c >= 0; c--)
         for (int p = 0; p < SPC; p++)
            rdq(0, c, p, 1, smp(0, c * SPC + p), "R5 frame 0 readback");
      rdq(1, 0, 0, 0, 0, "R6 wrong frame number");
      rdq(0, 7, 0, 0, 0, "R6 chip out of range");

      // R9 / R3: five more fill the 19 slots, the sixth overruns
      wr_range(1, 0, 4);
      chk(ovr === 0, "R9 no overrun at exactly DEPTH", ovr, 0);
      wr1(16'hdead, 0, 0);
      chk(ovr === 1, "R3 overrun flagged", ovr, 1);
      chk(frm_rdy === 1, "R4 frame 0 still ready", frm_rdy, 1);
      rdq(0, 0, 0, 1, smp(0, 0), "R3 dropped write left frame 0 intact");

      // R7 release and ignored release
      rel1();
      chk(oldest_idx === 1 && frm_rdy === 0, "R7 release advances",
          {oldest_idx, frm_rdy}, {3'd1, 1'b0});
      rel1();
      chk(oldest_idx === 1, "R7 release ignored when not ready", oldest_idx, 1);
      rdq(0, 0, 0, 0, 0, "R6 released frame no longer readable");

      // R8: frame 1 wraps past slot 18; R3: dropped sample not counted
      wr_range(1, 5, FS - 1);
      for (int c = 0; c < CHIPS; c++)
         for (int p = 0; p < SPC; p++)
            rdq(1, c, p, 1, smp(1, c * SPC + p), "R8 wrapped frame readback");
      rel1();
      chk(oldest_idx === 2, "R7 second release", oldest_idx, 2);

      // R2 index wrap, R8 bases moving around the store
      for (int f = 2; f <= 8; f++) begin
         wr_range(f, 0, FS - 1);
         rdq(f, 0, 0, 1, smp(f, 0), "R8 first sample");
         rdq(f, 6, 1, 1, smp(f, 13), "R8 last sample");
         rdq(f, 3, 0, 1, smp(f, 6), "R8 middle sample");
         rel1();
         chk(oldest_idx === FIW'((f + 1) % 8), "R7 oldest index", oldest_idx, (f + 1) % 8);
      end
      chk(ovr === 1, "R3 overrun sticky", ovr, 1);

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R5 all reads answered", sb.size(), 0);
      summary();
   end
endmodule